// File: doc/BRIEF.md
# Byte Permute Unit with Mask Register

This block executes two SIMD-style operations that cooperate through one 64-bit control register. The mask-set lane adds two 64-bit integers. It returns the full sum as its result and keeps the low 32 bits of that sum as a permutation mask in the upper half of the control register. The shuffle lane treats its two 64-bit operands as a single pool of sixteen bytes. It builds a 64-bit result from eight 4-bit selectors taken from the stored mask, one selector per result byte.

Both lanes have their own request strobe, so a mask-set and a shuffle may arrive in the same cycle. In that case the mask-set is ordered first, and the new mask is forwarded to the shuffle before it reaches the register. Each lane returns a registered result one cycle after its request, together with a one-cycle valid pulse. The control register is an output the surrounding logic can read at any time.

Top module: `byte_perm_unit`

## Requirements
- R1: A mask-set request returns `ms_a + ms_b` modulo 2^64 on `ms_res`, with `ms_res_vld` high, in the cycle after the request.
- R2: A mask-set writes the low 32 bits of its sum into `ctrl[63:32]`, visible in the cycle after the request. Without a mask-set request, `ctrl[63:32]` keeps its value.
- R3: `ctrl[31:0]` keeps its reset value of zero and no operation changes it.
- R4: The shuffle pool is indexed 0..15. Index 0 is the most significant byte of `sh_a` and index 7 its least significant byte. Indices 8..15 are the bytes of `sh_b`, also most significant first. The mask 0x01234567 therefore returns `sh_a` unchanged, and 0x89ABCDEF returns `sh_b`.
- R5: Result byte i (i = 0 for the most significant byte) is the pool byte named by mask bits [31-4i : 28-4i]. The mask 0x76543210 byte-reverses `sh_a`.
- R6: A selector is a plain 4-bit index, and the same pool byte may be chosen for any number of positions. With the reset mask of zero, a shuffle replicates the top byte of `sh_a` into all eight result bytes.
- R7: When a mask-set and a shuffle are requested in the same cycle, the shuffle uses the mask produced by that mask-set.
- R8: Each lane's valid output is high for exactly one cycle after each request and low otherwise. A lane's result holds its last value while that lane is idle.
- R9: During reset, `ctrl`, both results and both valids are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_req | input | 1 | Mask-set request strobe |
| ms_a | input | 64 | Mask-set first addend |
| ms_b | input | 64 | Mask-set second addend |
| sh_req | input | 1 | Shuffle request strobe |
| sh_a | input | 64 | Shuffle first operand (pool bytes 0..7) |
| sh_b | input | 64 | Shuffle second operand (pool bytes 8..15) |
| ms_res_vld | output | 1 | Mask-set result valid pulse |
| ms_res | output | 64 | Mask-set sum |
| sh_res_vld | output | 1 | Shuffle result valid pulse |
| sh_res | output | 64 | Permuted bytes |
| ctrl | output | 64 | Control register: mask in 63:32, zero in 31:0 |

## Verification
The hardest case to reach is a same-cycle pair in which the forwarded mask differs from the one already stored. A fault in the forwarding path only shows when the old mask and the new mask would select different bytes. The stimulus first loads a known mask. It then issues a mask-set and a shuffle together, with an addend pair whose sum gives a clearly different permutation. Random dual-issue cycles repeat the case against a reference that indexes a sixteen-byte array.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

endpackage

// File: rtl/bpu_mask_add.sv
module bpu_mask_add #(
    parameter int DATA_W = 64,
    parameter int MASK_W = 32
) (
    input  logic [DATA_W-1:0] add_x,
    input  logic [DATA_W-1:0] add_y,
    output logic [DATA_W-1:0] add_sum,
    output logic [MASK_W-1:0] add_mask
);

    always_comb begin
        add_sum  = add_x + add_y;
        add_mask = add_sum[MASK_W-1:0];
    end

endmodule

// File: rtl/bpu_byte_sel.sv
module bpu_byte_sel
    import bpu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]                         src_hi,
    input  logic [DATA_W-1:0]                         src_lo,
    input  logic [(DATA_W/BYTE_W)*$clog2(2*(DATA_W/BYTE_W))-1:0] sel_mask,
    output logic [DATA_W-1:0]                         perm_out
);

    localparam int NB     = DATA_W / BYTE_W;
    localparam int POOL_N = 2 * NB;
    localparam int SEL_W  = $clog2(POOL_N);
    localparam int MASK_W = NB * SEL_W;

    byte_t pool [POOL_N];

    // Pool entry 0 is the top byte of src_hi; entries NB.. come from src_lo.
    for (genvar p = 0; p < NB; p++) begin : g_pool
        assign pool[p]      = src_hi[DATA_W-1-BYTE_W*p -: BYTE_W];
        assign pool[NB + p] = src_lo[DATA_W-1-BYTE_W*p -: BYTE_W];
    end

    // Output byte k is picked by the k-th selector counted from the mask top.
    for (genvar k = 0; k < NB; k++) begin : g_lane
        logic [SEL_W-1:0] sel_k;
        assign sel_k = sel_mask[MASK_W-1-SEL_W*k -: SEL_W];
        assign perm_out[DATA_W-1-BYTE_W*k -: BYTE_W] = pool[sel_k];
    end

endmodule

// File: rtl/byte_perm_unit.sv
module byte_perm_unit
    import bpu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CTRL_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_req,
    input  logic [DATA_W-1:0] ms_a,
    input  logic [DATA_W-1:0] ms_b,
    input  logic              sh_req,
    input  logic [DATA_W-1:0] sh_a,
    input  logic [DATA_W-1:0] sh_b,
    output logic              ms_res_vld,
    output logic [DATA_W-1:0] ms_res,
    output logic              sh_res_vld,
    output logic [DATA_W-1:0] sh_res,
    output logic [CTRL_W-1:0] ctrl
);

    localparam int NB     = DATA_W / BYTE_W;
    localparam int SEL_W  = $clog2(2 * NB);
    localparam int MASK_W = NB * SEL_W;
    localparam int LOW_W  = CTRL_W - MASK_W;

    typedef struct packed {
        logic              ms_vld;
        logic [DATA_W-1:0] ms_val;
        logic              sh_vld;
        logic [DATA_W-1:0] sh_val;
        logic [MASK_W-1:0] mask;
        logic [LOW_W-1:0]  low;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] sum_w;
    logic [MASK_W-1:0] new_mask_w;
    logic [MASK_W-1:0] eff_mask_w;
    logic [DATA_W-1:0] perm_w;

    bpu_mask_add #(
        .DATA_W (DATA_W),
        .MASK_W (MASK_W)
    ) i_add (
        .add_x    (ms_a),
        .add_y    (ms_b),
        .add_sum  (sum_w),
        .add_mask (new_mask_w)
    );

    // Forward the pending mask write so a same-cycle shuffle sees it.
    always_comb begin
        eff_mask_w = ms_req ? new_mask_w : st_q.mask;
    end

    bpu_byte_sel #(
        .DATA_W (DATA_W)
    ) i_sel (
        .src_hi   (sh_a),
        .src_lo   (sh_b),
        .sel_mask (eff_mask_w),
        .perm_out (perm_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ms_vld = ms_req;
        st_d.sh_vld = sh_req;
        if (ms_req) begin
            st_d.ms_val = sum_w;
            st_d.mask   = new_mask_w;
        end
        if (sh_req) begin
            st_d.sh_val = perm_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ms_res_vld = st_q.ms_vld;
    assign ms_res     = st_q.ms_val;
    assign sh_res_vld = st_q.sh_vld;
    assign sh_res     = st_q.sh_val;
    assign ctrl       = {st_q.mask, st_q.low};

    AST_SUM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ms_res_vld |-> ms_res == $past(ms_a) + $past(ms_b)); // R1

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ms_res_vld |-> ctrl[CTRL_W-1 -: MASK_W] ==
            $past(ms_a[MASK_W-1:0]) + $past(ms_b[MASK_W-1:0])); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_res_vld |-> $stable(ctrl[CTRL_W-1 -: MASK_W])); // R2

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[LOW_W-1:0] == '0); // R3

    AST_SH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_res_vld == $past(sh_req)); // R8

    AST_SH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_res_vld |-> $stable(sh_res)); // R8

endmodule

// File: tb/test_byte_perm_unit.sv
module test_byte_perm_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam int NRAND      = 300;

    // Each entry: {mask to load, shuffle first operand, shuffle second operand}
    localparam logic [159:0] VEC [NVEC] = '{
        {32'h01234567, 64'h1122334455667788, 64'h99AABBCCDDEEFF00},
        {32'h76543210, 64'h0102030405060708, 64'hA1A2A3A4A5A6A7A8},
        {32'h89ABCDEF, 64'hDEADBEEFCAFEF00D, 64'h0F1E2D3C4B5A6978},
        {32'hFEDCBA98, 64'h1357924680ACE0BD, 64'h8877665544332211},
        {32'h08192A3B, 64'hC0C1C2C3C4C5C6C7, 64'hD0D1D2D3D4D5D6D7},
        {32'hFFFFFFFF, 64'h0011223344556677, 64'h8899AABBCCDDEEF1},
        {32'h77777777, 64'h5A5A5A5A5A5A5A3C, 64'h0000000000000000},
        {32'h4C4C0F0F, 64'h1020304050607080, 64'h90A0B0C0D0E0F0FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_req = 1'b0;
    logic [63:0] ms_a = '0;
    logic [63:0] ms_b = '0;
    logic        sh_req = 1'b0;
    logic [63:0] sh_a = '0;
    logic [63:0] sh_b = '0;
    logic        ms_res_vld;
    logic [63:0] ms_res;
    logic        sh_res_vld;
    logic [63:0] sh_res;
    logic [63:0] ctrl;

    int checks = 0;
    int errors = 0;
    logic [31:0] ref_mask = '0;
    logic [63:0] last_sh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_perm_unit i_byte_perm_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_req     (ms_req),
        .ms_a       (ms_a),
        .ms_b       (ms_b),
        .sh_req     (sh_req),
        .sh_a       (sh_a),
        .sh_b       (sh_b),
        .ms_res_vld (ms_res_vld),
        .ms_res     (ms_res),
        .sh_res_vld (sh_res_vld),
        .sh_res     (sh_res),
        .ctrl       (ctrl)
    );

    function automatic logic [63:0] ref_shuffle(logic [31:0] m, logic [63:0] x, logic [63:0] y);
        logic [7:0]  bytes [16];
        logic [63:0] r;
        for (int j = 0; j < 8; j++) begin
            bytes[j]     = x[63-8*j -: 8];
            bytes[8 + j] = y[63-8*j -: 8];
        end
        r = '0;
        for (int j = 0; j < 8; j++) begin
            r[63-8*j -: 8] = bytes[m[31-4*j -: 4]];
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of requests at a falling edge; outputs are sampled at the next one.
    task automatic issue(logic mv, logic [63:0] ma, logic [63:0] mb,
                         logic sv, logic [63:0] sa, logic [63:0] sb);
        ms_req = mv; ms_a = ma; ms_b = mb;
        sh_req = sv; sh_a = sa; sh_b = sb;
        @(negedge clk);
        ms_req = 1'b0;
        sh_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb, sa, sb, sum, exp_sh;
        logic        mv, sv;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 ctrl", ctrl, 64'd0);
        check("R9 valids", {62'd0, ms_res_vld, sh_res_vld}, 64'd0);
        check("R9 results", ms_res | sh_res, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: zero mask replicates the top byte of the first operand
        issue(1'b0, '0, '0, 1'b1, 64'hA5123456789ABCDE, 64'hFFEEDDCCBBAA9988);
        check("R6 zero mask", sh_res, 64'hA5A5A5A5A5A5A5A5);
        check("R8 shuffle valid", {63'd0, sh_res_vld}, 64'd1);
        check("R8 no ms valid", {63'd0, ms_res_vld}, 64'd0);

        // Table: load mask through mask-set, then shuffle in the following cycle
        for (int v = 0; v < NVEC; v++) begin
            issue(1'b1, {32'h0, VEC[v][159:128]} + 64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 1'b0, '0, '0);
            check("R1 sum", ms_res, {32'h0, VEC[v][159:128]});
            check("R2 mask write", {32'h0, ctrl[63:32]}, {32'h0, VEC[v][159:128]});
            check("R3 low half", {32'h0, ctrl[31:0]}, 64'd0);
            ref_mask = VEC[v][159:128];
            issue(1'b0, '0, '0, 1'b1, VEC[v][127:64], VEC[v][63:0]);
            check("R5 table shuffle", sh_res, ref_shuffle(ref_mask, VEC[v][127:64], VEC[v][63:0]));
            if (v == 0) check("R4 identity", sh_res, VEC[v][127:64]);
            if (v == 1) check("R5 byte reverse", sh_res, 64'h0807060504030201);
            if (v == 2) check("R4 second operand", sh_res, VEC[v][63:0]);
            if (v == 5) check("R6 repeated pick", sh_res, 64'hF1F1F1F1F1F1F1F1);
        end

        // R7: same-cycle pair; old mask 0x4C4C0F0F, new one is byte reverse
        issue(1'b1, 64'h0000_0000_7654_0000, 64'h0000_0000_0000_3210, 1'b1,
              64'h0102030405060708, 64'h1112131415161718);
        check("R7 forwarded mask", sh_res, 64'h0807060504030201);
        check("R7 ctrl", {32'h0, ctrl[63:32]}, 64'h76543210);
        ref_mask = 32'h76543210;
        last_sh = sh_res;

        // R8 / R2: idle cycle holds state and drops valids
        issue(1'b0, 64'hFFFF, 64'hFFFF, 1'b0, 64'h1, 64'h2);
        check("R8 valids low", {62'd0, ms_res_vld, sh_res_vld}, 64'd0);
        check("R8 result hold", sh_res, last_sh);
        check("R2 mask hold", {32'h0, ctrl[63:32]}, 64'h76543210);

        // Random traffic, including dual issue, against the reference
        for (int n = 0; n < NRAND; n++) begin
            mv = 1'($urandom_range(0, 1));
            sv = 1'($urandom_range(0, 1));
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            sa = {$urandom, $urandom};
            sb = {$urandom, $urandom};
            sum = ra + rb;
            if (mv) ref_mask = sum[31:0];
            exp_sh = ref_shuffle(ref_mask, sa, sb);
            issue(mv, ra, rb, sv, sa, sb);
            check("R8 ms valid", {63'd0, ms_res_vld}, {63'd0, mv});
            check("R8 sh valid", {63'd0, sh_res_vld}, {63'd0, sv});
            if (mv) check("R1 random sum", ms_res, sum);
            if (sv) check("R7 random shuffle", sh_res, exp_sh);
            check("R2 random ctrl", ctrl, {ref_mask, 32'h0});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule